// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a simple 32-bit processor pipeline and chooses its next value on every clock. Each cycle the counter takes one of three paths. It can step forward by one instruction word. It can move by a signed word distance measured from the following instruction when a conditional branch resolves as taken. It can also take an absolute jump that stays within the current 256 MB region of the address space.

The decode stage supplies three control levels: a branch-if-equal request, a branch-if-different request and a jump request. It also supplies the raw 16-bit branch displacement and the 26-bit jump field. The execute stage provides a single flag that says whether the two compared registers hold equal values. The counter holds only word addresses. Its two least significant bits are not stored and always read as zero.

Reset is asynchronous and active low. The block synchronises its release internally, and then the counter starts from a word-aligned start address given as a parameter.

Top module: `npc_unit`

## Requirements
- R1: While reset is applied, and for the two clock edges after `rst_n` rises, `pc_o` equals the parameter `START_ADDR` (a multiple of 4).
- R2: With `jump_i`, `br_eq_i` and `br_ne_i` all low, each clock edge advances `pc_o` by 4.
- R3: With `br_eq_i` high, `jump_i` low and `ops_equal_i` high, the next `pc_o` is `pc_o + 4 + 4*off`. Here `off` is `br_off_i` read as a two's-complement number.
- R4: With `br_eq_i` high, `br_ne_i` low and `ops_equal_i` low, the branch is not taken and the next `pc_o` is `pc_o + 4`.
- R5: `br_ne_i` takes the branch of R3 when `ops_equal_i` is low. When `ops_equal_i` is high it falls through to `pc_o + 4`.
- R6: With `jump_i` high, the next `pc_o` is built from three parts: bits 31..28 of the current `pc_o`, then `jump_tgt_i`, then two zero bits.
- R7: When `jump_i` is high together with a branch request whose condition holds, the jump wins.
- R8: Branch displacements cover the full signed range, from -32768 words (0x8000) to +32767 words (0x7FFF).
- R9: Bits 1..0 of `pc_o` are zero at all times.
- R10: All arithmetic is modulo 2^32. From 0xFFFFFFFC the next sequential address is 0x00000000.
- R11: The upper four bits that a jump keeps come from the current PC and not from PC+4. From 0xFFFFFFFC, a jump lands in the region 0xF0000000..0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| jump_i | input | 1 | Absolute region jump request |
| br_eq_i | input | 1 | Branch request, taken when operands are equal |
| br_ne_i | input | 1 | Branch request, taken when operands differ |
| ops_equal_i | input | 1 | High when the two compared registers are equal |
| br_off_i | input | 16 | Signed branch displacement in instruction words |
| jump_tgt_i | input | 26 | Word-index jump field |
| pc_o | output | 32 | Current program counter |

## Verification
A jump request and a branch request whose condition holds can arrive in the same cycle. The bench raises `jump_i` together with `br_eq_i` (with equal operands) and together with `br_ne_i` (with differing operands). It picks offsets and targets so that the branch destination and the jump destination differ, and it passes only if the counter lands on the jump destination. A second coincidence is the sequential wrap at the top of the address space against a jump made from that same address. That case shows the region bits come from the PC before the increment.

// File: rtl/npc_pkg.sv
package npc_pkg;

  // Next-value source selected each cycle
  typedef enum logic [1:0] {
    NXT_SEQ  = 2'd0,
    NXT_BR   = 2'd1,
    NXT_JUMP = 2'd2
  } nxt_sel_e;

endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/npc_cond.sv
module npc_cond (
  input  logic jump_i,
  input  logic br_eq_i,
  input  logic br_ne_i,
  input  logic ops_equal_i,
  output npc_pkg::nxt_sel_e sel_o
);

  logic eq_hit;
  logic ne_hit;

  always_comb begin
    eq_hit = br_eq_i &  ops_equal_i;
    ne_hit = br_ne_i & ~ops_equal_i;
    if (jump_i) begin
      sel_o = npc_pkg::NXT_JUMP;
    end else if (eq_hit | ne_hit) begin
      sel_o = npc_pkg::NXT_BR;
    end else begin
      sel_o = npc_pkg::NXT_SEQ;
    end
  end

endmodule

// File: rtl/npc_tgt.sv
module npc_tgt #(
  parameter int WORD_W = 30,
  parameter int OFF_W  = 16,
  parameter int TGT_W  = 26
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [TGT_W-1:0]  tgt_i,
  output logic [WORD_W-1:0] seq_o,
  output logic [WORD_W-1:0] br_o,
  output logic [WORD_W-1:0] jump_o
);

  localparam int EXT_W = WORD_W - OFF_W;
  localparam int HI_W  = WORD_W - TGT_W;

  logic [WORD_W-1:0] off_ext;

  always_comb begin
    off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
    seq_o   = word_i + WORD_W'(1);
    br_o    = seq_o + off_ext;
    jump_o  = {word_i[WORD_W-1 -: HI_W], tgt_i};
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int               PC_W       = 32,
  parameter int               OFF_W      = 16,
  parameter int               TGT_W      = 26,
  parameter logic [PC_W-1:0]  START_ADDR = 32'h0040_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             jump_i,
  input  logic             br_eq_i,
  input  logic             br_ne_i,
  input  logic             ops_equal_i,
  input  logic [OFF_W-1:0] br_off_i,
  input  logic [TGT_W-1:0] jump_tgt_i,
  output logic [PC_W-1:0]  pc_o
);

  localparam int                WORD_W     = PC_W - 2;
  localparam logic [WORD_W-1:0] START_WORD = START_ADDR[PC_W-1:2];

  logic                rst_q_n;
  logic [WORD_W-1:0]   word_q;
  logic [WORD_W-1:0]   word_d;
  logic [WORD_W-1:0]   seq_w;
  logic [WORD_W-1:0]   br_w;
  logic [WORD_W-1:0]   jump_w;
  logic                word_en;
  npc_pkg::nxt_sel_e   sel;

  npc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  npc_cond u_cond (
    .jump_i      (jump_i),
    .br_eq_i     (br_eq_i),
    .br_ne_i     (br_ne_i),
    .ops_equal_i (ops_equal_i),
    .sel_o       (sel)
  );

  npc_tgt #(.WORD_W(WORD_W), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_tgt (
    .word_i (word_q),
    .off_i  (br_off_i),
    .tgt_i  (jump_tgt_i),
    .seq_o  (seq_w),
    .br_o   (br_w),
    .jump_o (jump_w)
  );

  always_comb begin
    word_en = rst_q_n;
    unique case (sel)
      npc_pkg::NXT_JUMP: word_d = jump_w;
      npc_pkg::NXT_BR:   word_d = br_w;
      default:           word_d = seq_w;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      word_q <= START_WORD;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign pc_o = {word_q, 2'b00};

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int TGT_W = 26
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             jump_i,
  input logic             br_eq_i,
  input logic             br_ne_i,
  input logic             ops_equal_i,
  input logic [OFF_W-1:0] br_off_i,
  input logic [TGT_W-1:0] jump_tgt_i,
  input logic [PC_W-1:0]  pc_o
);

  localparam int HI_W = PC_W - 2 - TGT_W;

  logic [PC_W-1:0] disp;
  logic            eq_take;
  logic            ne_take;

  always_comb begin
    disp    = {{(PC_W-OFF_W-2){br_off_i[OFF_W-1]}}, br_off_i, 2'b00};
    eq_take = br_eq_i && ops_equal_i;
    ne_take = br_ne_i && !ops_equal_i;
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!jump_i && !eq_take && !ne_take) |=> (pc_o == $past(pc_o) + PC_W'(4))); // R2

  AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!jump_i && eq_take) |=> (pc_o == $past(pc_o) + PC_W'(4) + $past(disp))); // R3

  AST_BNE_TAKEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!jump_i && ne_take) |=> (pc_o == $past(pc_o) + PC_W'(4) + $past(disp))); // R5

  AST_JUMP_DEST: assert property (@(posedge clk) disable iff (!rst_q_n)
    jump_i |=> (pc_o == {$past(pc_o[PC_W-1 -: HI_W]), $past(jump_tgt_i), 2'b00})); // R7

  AST_PC_STABLE_ALIGN: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(rst_q_n) |-> (pc_o[1:0] == $past(pc_o[1:0]))); // R9

endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .jump_i      (jump_i),
  .br_eq_i     (br_eq_i),
  .br_ne_i     (br_ne_i),
  .ops_equal_i (ops_equal_i),
  .br_off_i    (br_off_i),
  .jump_tgt_i  (jump_tgt_i),
  .pc_o        (pc_o)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

  localparam logic [31:0] START = 32'hFFFF_FFF0;

  logic        clk;
  logic        rst_n;
  logic        jump_i;
  logic        br_eq_i;
  logic        br_ne_i;
  logic        ops_equal_i;
  logic [15:0] br_off_i;
  logic [25:0] jump_tgt_i;
  logic [31:0] pc_o;

  int checks;
  int errors;
  logic [31:0] model_pc;

  npc_unit #(.START_ADDR(START)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .jump_i      (jump_i),
    .br_eq_i     (br_eq_i),
    .br_ne_i     (br_ne_i),
    .ops_equal_i (ops_equal_i),
    .br_off_i    (br_off_i),
    .jump_tgt_i  (jump_tgt_i),
    .pc_o        (pc_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle of controls at the falling edge, let one rising edge pass,
  // then compare against the bench model.
  task automatic step(input logic j, input logic be, input logic bn, input logic eq,
                      input logic [15:0] off, input logic [25:0] tgt, input string tag);
    logic [31:0] disp;
    @(negedge clk);
    jump_i = j; br_eq_i = be; br_ne_i = bn; ops_equal_i = eq;
    br_off_i = off; jump_tgt_i = tgt;
    disp = {{14{off[15]}}, off, 2'b00};
    if (j)                          model_pc = {model_pc[31:28], tgt, 2'b00};
    else if ((be && eq) || (bn && !eq)) model_pc = model_pc + 32'd4 + disp;
    else                            model_pc = model_pc + 32'd4;
    @(posedge clk);
    #1;
    check(tag, pc_o, model_pc);
    check({tag, "/R9"}, {30'd0, pc_o[1:0]}, 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    jump_i = 0; br_eq_i = 0; br_ne_i = 0; ops_equal_i = 0;
    br_off_i = '0; jump_tgt_i = '0;
    rst_n = 1'b0;
    #1;
    check("R1 async reset", pc_o, START);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 hold edge 1", pc_o, START);
    @(posedge clk); #1;
    check("R1 hold edge 2", pc_o, START);
    model_pc = START;
  endtask

  task automatic t_wrap();
    step(0, 0, 0, 0, 16'h0000, 26'h0, "R2 seq");
    step(0, 0, 0, 0, 16'h0000, 26'h0, "R2 seq");
    step(0, 0, 0, 0, 16'h0000, 26'h0, "R2 seq");
    check("R10 at top", pc_o, 32'hFFFF_FFFC);
    step(0, 0, 0, 0, 16'h0000, 26'h0, "R10 wrap");
    check("R10 wrapped", pc_o, 32'h0000_0000);
  endtask

  task automatic t_region_from_pc();
    do_reset();
    step(0, 0, 0, 0, 16'h0, 26'h0, "R2 seq");
    step(0, 0, 0, 0, 16'h0, 26'h0, "R2 seq");
    step(0, 0, 0, 0, 16'h0, 26'h0, "R2 seq");
    step(1, 0, 0, 0, 16'h0, 26'h000_0010, "R11 jump from top");
    check("R11 region", pc_o, 32'hF000_0040);
  endtask

  task automatic t_branches();
    step(0, 1, 0, 1, 16'h0005, 26'h0, "R3 beq taken");
    step(0, 1, 0, 0, 16'h0005, 26'h0, "R4 beq not taken");
    step(0, 0, 1, 0, 16'hFFFE, 26'h0, "R5 bne taken back");
    step(0, 0, 1, 1, 16'h0040, 26'h0, "R5 bne not taken");
    step(0, 1, 0, 1, 16'hFFFF, 26'h0, "R3 beq self loop");
  endtask

  task automatic t_range();
    step(0, 1, 0, 1, 16'h7FFF, 26'h0, "R8 max forward");
    step(0, 0, 1, 0, 16'h8000, 26'h0, "R8 max backward");
    step(0, 0, 1, 0, 16'h8000, 26'h0, "R8 max backward again");
  endtask

  task automatic t_jump_prio();
    step(1, 0, 0, 0, 16'h0, 26'h123_4567, "R6 plain jump");
    step(1, 1, 0, 1, 16'h0100, 26'h000_0ABC, "R7 jump over beq");
    step(1, 0, 1, 0, 16'h0200, 26'h3FF_FFFF, "R7 jump over bne");
    step(0, 0, 0, 0, 16'h0, 26'h0, "R2 after jump");
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0;
    jump_i = 0; br_eq_i = 0; br_ne_i = 0; ops_equal_i = 0;
    br_off_i = '0; jump_tgt_i = '0;
    model_pc = START;
    repeat (2) @(posedge clk);
    do_reset();
    t_wrap();
    t_branches();
    t_range();
    t_jump_prio();
    t_region_from_pc();
    t_branches();
    do_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule